// File: doc/BRIEF.md
# Floating-Point Status Register Write Unit

This block holds the 64-bit floating-point status and control register of a processor core and carries out the two instructions that move values into it. The field-mask form copies selected 4-bit fields from a 64-bit source operand. The immediate form places a 4-bit constant from the instruction word into one chosen field. The 64-bit register is treated as sixteen 4-bit fields, with field i covering bits 4i+3 down to 4i. A W bit in the instruction moves the field selection into the upper half of the register. W may be used only when the core reports support for the extended instruction set.

The issuing pipeline presents a request with the instruction word already classified by form. With the request it gives the source operand, an FPU-enabled flag and the extended-support flag. One clock edge later the register holds its new value, or one of two exception pulses reports why nothing was written. Two summary bits are never copied from the source. After every write they are computed again from the sticky and enable bits. A read port returns either 32-bit half of the register.

Top module: `fpstat_wr_unit`

## Requirements
- R1: After reset the register is all zeros and both exception outputs are low.
- R2: Field-mask form (form_imm_i=0) with L (insn bit 25) clear and W (insn bit 16) clear: each bit k of the 8-bit field mask at insn bits 24:17 enables a copy of source field k into the register, and fields that are not enabled keep their value.
- R3: Field-mask form with L clear, W set and the extended-support flag set: mask bit k selects field k+8 instead of field k.
- R4: Field-mask form with L set: the value of the mask field is ignored. All sixteen fields are written when the extended-support flag is set, and fields 0 to 7 only when it is clear.
- R5: Immediate form (form_imm_i=1): the 4-bit value at insn bits 15:12 is written into field 8*W + 7 - S, where S is the 3-bit selector at insn bits 21:19. No other field changes, and the source operand is ignored.
- R6: Bits 29 and 30 are never copied from the source. After each write, bit 29 is the OR of the invalid-operation sticky bits 24..19 and 10..8. Bit 30 is the OR over k=0..4 of (bit 29-k AND bit 7-k), using the new bit 29.
- R7: A request with W set while the extended-support flag is clear leaves the register unchanged and raises illegal_o for one cycle.
- R8: A request with the FPU disabled leaves the register unchanged and raises unavail_o for one cycle. This check takes priority over R7, so illegal_o stays low.
- R9: The new register value and the exception pulses appear on the clock edge that samples the request. With no request, the register holds its value and both pulses are low.
- R10: rd_word_o returns register bits 63:32 when rd_hi_i is 1, and bits 31:0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Write request valid |
| form_imm_i | input | 1 | 1 selects the immediate form, 0 the field-mask form |
| insn_i | input | 32 | Decoded instruction word |
| src_i | input | REG_W | Source operand for the field-mask form |
| fpu_en_i | input | 1 | FPU enabled |
| ext_isa_i | input | 1 | Extended instruction-set support present |
| rd_hi_i | input | 1 | Read-port half select |
| stat_o | output | REG_W | Current register value |
| rd_word_o | output | REG_W/2 | Selected half of the register |
| unavail_o | output | 1 | FPU-unavailable exception pulse |
| illegal_o | output | 1 | Illegal-instruction exception pulse |

## Verification
The bench builds the block with the default REG_W of 64. This gives the full sixteen fields, so a W shift can reach fields 8 to 15 and the L form can write all sixteen. At this width the immediate selector reaches both the lowest and the highest field of each half. It also puts every invalid-operation sticky bit and every enable pair in the lower word, where source patterns can set the two summary bits and leave them clear again.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
    localparam int NIB_W    = 4;
    // instruction word field positions
    localparam int L_POS    = 25;
    localparam int MSK_POS  = 17;
    localparam int W_POS    = 16;
    localparam int SEL_POS  = 19;
    localparam int SEL_W    = 3;
    localparam int IMM_POS  = 12;
    // summary bits and their sources
    localparam int VX_BIT   = 29;
    localparam int FEX_BIT  = 30;
    localparam int N_EXC    = 5;   // sticky 29..25 pair with enable 7..3
    localparam logic [31:0] INV_MASK = 32'h01F8_0700;
endpackage

// File: rtl/fpstat_decode.sv
module fpstat_decode
    import fpstat_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic                      form_imm,
    input  logic [31:0]               insn,
    input  logic [REG_W-1:0]          src,
    input  logic                      ext_isa,
    output logic [REG_W-1:0]          wr_data,
    output logic [REG_W/NIB_W-1:0]    wr_mask,
    output logic                      w_bad
);
    localparam int FIELDS = REG_W / NIB_W;
    localparam int HALF   = FIELDS / 2;
    localparam int SH_W   = $clog2(FIELDS);

    logic            w_bit;
    logic            l_bit;
    logic [HALF-1:0] flm;
    logic [SEL_W-1:0] sel;
    logic [NIB_W-1:0] imm;
    logic [SH_W-1:0] sh;

    assign w_bit = insn[W_POS];
    assign l_bit = insn[L_POS];
    assign flm   = insn[MSK_POS +: HALF];
    assign sel   = insn[SEL_POS +: SEL_W];
    assign imm   = insn[IMM_POS +: NIB_W];
    assign w_bad = w_bit & ~ext_isa;

    always_comb begin
        sh = (w_bit ? SH_W'(HALF) : '0) + SH_W'(HALF - 1) - SH_W'(sel);
        if (form_imm) begin
            wr_data     = REG_W'(imm) << (NIB_W * sh);
            wr_mask     = '0;
            wr_mask[sh] = 1'b1;
        end else begin
            wr_data = src;
            if (l_bit) begin
                wr_mask = ext_isa ? '1 : FIELDS'({HALF{1'b1}});
            end else begin
                wr_mask = FIELDS'(flm) << (w_bit ? HALF : 0);
            end
        end
    end
endmodule

// File: rtl/fpstat_merge.sv
module fpstat_merge
    import fpstat_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0]       prev,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [REG_W/NIB_W-1:0] wr_mask,
    output logic [REG_W-1:0]       merged
);
    localparam int FIELDS = REG_W / NIB_W;

    logic [REG_W-1:0] raw;
    logic             vx;
    logic             fex;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        assign raw[i*NIB_W +: NIB_W] = wr_mask[i] ? wr_data[i*NIB_W +: NIB_W]
                                                  : prev[i*NIB_W +: NIB_W];
    end

    always_comb begin
        vx  = |(raw[31:0] & INV_MASK);
        fex = 1'b0;
        for (int k = 0; k < N_EXC; k++) begin
            if (k == 0) fex = fex | (vx & raw[7]);
            else        fex = fex | (raw[VX_BIT-k] & raw[7-k]);
        end
        merged          = raw;
        merged[VX_BIT]  = vx;
        merged[FEX_BIT] = fex;
    end
endmodule

// File: rtl/fpstat_wr_unit.sv
module fpstat_wr_unit
    import fpstat_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               form_imm_i,
    input  logic [31:0]        insn_i,
    input  logic [REG_W-1:0]   src_i,
    input  logic               fpu_en_i,
    input  logic               ext_isa_i,
    input  logic               rd_hi_i,
    output logic [REG_W-1:0]   stat_o,
    output logic [REG_W/2-1:0] rd_word_o,
    output logic               unavail_o,
    output logic               illegal_o
);
    localparam int FIELDS = REG_W / NIB_W;
    localparam int HW     = REG_W / 2;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic             unavail;
        logic             illegal;
    } state_t;

    state_t state_d, state_q;

    logic [REG_W-1:0]  wr_data;
    logic [FIELDS-1:0] wr_mask;
    logic              w_bad;
    logic [REG_W-1:0]  merged;

    fpstat_decode #(.REG_W(REG_W)) u_decode (
        .form_imm (form_imm_i),
        .insn     (insn_i),
        .src      (src_i),
        .ext_isa  (ext_isa_i),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .w_bad    (w_bad)
    );

    fpstat_merge #(.REG_W(REG_W)) u_merge (
        .prev    (state_q.stat),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .merged  (merged)
    );

    always_comb begin
        state_d         = state_q;
        state_d.unavail = 1'b0;
        state_d.illegal = 1'b0;
        if (req_i) begin
            if (!fpu_en_i) begin
                state_d.unavail = 1'b1;
            end else if (w_bad) begin
                state_d.illegal = 1'b1;
            end else begin
                state_d.stat = merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stat_o    = state_q.stat;
    assign unavail_o = state_q.unavail;
    assign illegal_o = state_q.illegal;
    assign rd_word_o = rd_hi_i ? state_q.stat[REG_W-1:HW] : state_q.stat[HW-1:0];

    // R8
    unavail_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !fpu_en_i) |=> (unavail_o && !illegal_o && $stable(stat_o)));

    // R7
    illegal_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && fpu_en_i && insn_i[W_POS] && !ext_isa_i) |=> (illegal_o && $stable(stat_o)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!unavail_o && !illegal_o && $stable(stat_o)));

    // R6
    vx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[VX_BIT] == |(stat_o[31:0] & INV_MASK));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(unavail_o && illegal_o));
endmodule

// File: tb/fpstat_wr_unit_test.sv
module fpstat_wr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        form_imm_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] src_i = '0;
    logic        fpu_en_i = 1'b1;
    logic        ext_isa_i = 1'b1;
    logic        rd_hi_i = 1'b0;
    logic [63:0] stat_o;
    logic [31:0] rd_word_o;
    logic        unavail_o;
    logic        illegal_o;

    int tests_run = 0;
    int tests_failed = 0;
    logic [63:0] expect_q = '0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fpstat_wr_unit uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .form_imm_i(form_imm_i),
        .insn_i(insn_i), .src_i(src_i), .fpu_en_i(fpu_en_i), .ext_isa_i(ext_isa_i),
        .rd_hi_i(rd_hi_i), .stat_o(stat_o), .rd_word_o(rd_word_o),
        .unavail_o(unavail_o), .illegal_o(illegal_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        tests_run++;
        if (act !== exp_v) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // expected value built from the requirement text
    function automatic logic [63:0] fix_summary(input logic [63:0] v);
        logic [63:0] r = v;
        logic vx = 1'b0;
        logic fex = 1'b0;
        for (int b = 19; b <= 24; b++) vx = vx | r[b];
        for (int b = 8; b <= 10; b++) vx = vx | r[b];
        r[29] = vx;
        for (int k = 0; k < 5; k++) fex = fex | (r[29-k] & r[7-k]);
        r[30] = fex;
        return r;
    endfunction

    function automatic logic [31:0] mk_field(input bit l, input bit w, input logic [7:0] m);
        return (32'(l) << 25) | (32'(m) << 17) | (32'(w) << 16);
    endfunction

    function automatic logic [31:0] mk_imm(input bit w, input logic [2:0] s, input logic [3:0] v);
        return (32'(s) << 19) | (32'(w) << 16) | (32'(v) << 12);
    endfunction

    task automatic issue(input bit imm, input logic [31:0] ins, input logic [63:0] src,
                         input bit fen, input bit ext);
        @(negedge clk);
        req_i = 1'b1; form_imm_i = imm; insn_i = ins; src_i = src;
        fpu_en_i = fen; ext_isa_i = ext;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic write_fields(input string tag, input int first, input int last,
                                input logic [63:0] src);
        for (int f = first; f <= last; f++) expect_q[f*4 +: 4] = src[f*4 +: 4];
        expect_q = fix_summary(expect_q);
        check(tag, stat_o, expect_q);
        check({tag, " pulses"}, {62'd0, unavail_o, illegal_o}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 reset value", stat_o, 64'd0);
        check("R1 reset pulses", {62'd0, unavail_o, illegal_o}, 64'd0);
    endtask

    task automatic t_mask_low();
        logic [63:0] s = 64'h0123_4567_89AB_CDEF;
        issue(1'b0, mk_field(1'b0, 1'b0, 8'h81), s, 1'b1, 1'b1);
        expect_q[3:0] = s[3:0]; expect_q[31:28] = s[31:28];
        expect_q = fix_summary(expect_q);
        check("R2 mask 0x81", stat_o, expect_q);
        check("R2 R6 hand value", stat_o, 64'h0000_0000_8000_000F);
    endtask

    task automatic t_mask_high();
        logic [63:0] s = 64'hFEDC_BA98_7654_3210;
        issue(1'b0, mk_field(1'b0, 1'b1, 8'h0F), s, 1'b1, 1'b1);
        write_fields("R3 W shifts to fields 8-11", 8, 11, s);
    endtask

    task automatic t_l_form();
        logic [63:0] s = 64'hA5A5_A5A5_5A5A_5A5A;
        issue(1'b0, mk_field(1'b1, 1'b0, 8'h00), s, 1'b1, 1'b0);
        write_fields("R4 L no ext lower 8", 0, 7, s);
        s = 64'h1357_9BDF_0246_8ACE;
        issue(1'b0, mk_field(1'b1, 1'b0, 8'h01), s, 1'b1, 1'b1);
        write_fields("R4 L ext all 16", 0, 15, s);
    endtask

    task automatic t_imm();
        logic [63:0] junk = 64'hFFFF_FFFF_FFFF_FFFF;
        issue(1'b1, mk_imm(1'b0, 3'd0, 4'hA), junk, 1'b1, 1'b1);
        expect_q[31:28] = 4'hA; expect_q = fix_summary(expect_q);
        check("R5 imm sel0 -> field7", stat_o, expect_q);
        issue(1'b1, mk_imm(1'b1, 3'd7, 4'h6), junk, 1'b1, 1'b1);
        expect_q[35:32] = 4'h6; expect_q = fix_summary(expect_q);
        check("R5 imm W sel7 -> field8", stat_o, expect_q);
        issue(1'b1, mk_imm(1'b1, 3'd0, 4'h9), junk, 1'b1, 1'b1);
        expect_q[63:60] = 4'h9; expect_q = fix_summary(expect_q);
        check("R5 imm W sel0 -> field15", stat_o, expect_q);
    endtask

    task automatic t_summary();
        // clear lower word, then set one invalid sticky and the enable bit 7
        issue(1'b0, mk_field(1'b0, 1'b0, 8'hFF), 64'h0, 1'b1, 1'b1);
        expect_q[31:0] = '0;
        check("R6 cleared lower", stat_o, expect_q);
        issue(1'b0, mk_field(1'b0, 1'b0, 8'hFF), 64'h0000_0000_0100_0080, 1'b1, 1'b1);
        expect_q[31:0] = 32'h6100_0080;
        check("R6 VX and FEX set", stat_o, expect_q);
        issue(1'b0, mk_field(1'b0, 1'b0, 8'hFF), 64'h0000_0000_6000_0000, 1'b1, 1'b1);
        expect_q[31:0] = 32'h0;
        check("R6 summary bits not from source", stat_o, expect_q);
        issue(1'b0, mk_field(1'b0, 1'b0, 8'hFF), 64'h0000_0000_0400_0010, 1'b1, 1'b1);
        expect_q[31:0] = 32'h4400_0010;
        check("R6 FEX from divide pair", stat_o, expect_q);
    endtask

    task automatic t_illegal();
        issue(1'b0, mk_field(1'b0, 1'b1, 8'hFF), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        check("R7 field form unchanged", stat_o, expect_q);
        check("R7 illegal pulse", {62'd0, unavail_o, illegal_o}, 64'd1);
        issue(1'b1, mk_imm(1'b1, 3'd3, 4'hF), 64'h0, 1'b1, 1'b0);
        check("R7 imm form unchanged", stat_o, expect_q);
        check("R7 imm illegal pulse", {62'd0, unavail_o, illegal_o}, 64'd1);
        @(negedge clk);
        check("R9 pulse lasts one cycle", {62'd0, unavail_o, illegal_o}, 64'd0);
    endtask

    task automatic t_disabled();
        issue(1'b0, mk_field(1'b0, 1'b1, 8'hFF), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        check("R8 unchanged", stat_o, expect_q);
        check("R8 unavail over illegal", {62'd0, unavail_o, illegal_o}, 64'd2);
        issue(1'b0, mk_field(1'b0, 1'b0, 8'hFF), 64'h0, 1'b0, 1'b1);
        check("R8 plain unchanged", stat_o, expect_q);
    endtask

    task automatic t_idle();
        @(negedge clk);
        form_imm_i = 1'b0; insn_i = mk_field(1'b1, 1'b0, 8'hFF); src_i = '0;
        fpu_en_i = 1'b1; ext_isa_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 no request holds", stat_o, expect_q);
        check("R9 no request pulses", {62'd0, unavail_o, illegal_o}, 64'd0);
    endtask

    task automatic t_read();
        rd_hi_i = 1'b0; #1;
        check("R10 lower half", {32'd0, rd_word_o}, {32'd0, expect_q[31:0]});
        rd_hi_i = 1'b1; #1;
        check("R10 upper half", {32'd0, rd_word_o}, {32'd0, expect_q[63:32]});
        rd_hi_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_low();
        t_mask_high();
        t_imm();
        t_read();
        t_l_form();
        t_summary();
        t_illegal();
        t_disabled();
        t_idle();
        t_read();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end
endmodule